// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory Word Guard

This block protects words on a memory data path with an extended Hamming code. On the write side, it turns each data word into a codeword that carries check bits and an overall parity bit. On the read side, it takes a stored codeword and the address it was read from. One clock later it returns the data word, with any single flipped bit repaired. It also flags whether a repair was made or whether the word is beyond repair.

Around the decoder sits a small error log. It counts the repaired reads in a counter that stops at its maximum value. It keeps the address of the most recent repaired read. An unrepairable read sets an interrupt line that stays high until the host pulses a clear input. The page holding that read is also entered into a small table of bad pages. A default data word is 64 bits, which gives a 72-bit codeword.

Top module: `secded_guard`

## Requirements
- R1: `wr_code` is a combinational function of `wr_data`. Codeword bit i, for i from 1 to 71, is Hamming position i. Check bits sit at positions 1, 2, 4, 8, 16, 32 and 64, and check bit 2^k is the even parity of all other positions whose index has bit k set. Data bit 0 and upward fill the remaining positions in ascending order. Bit 0 makes the parity of all 72 bits even.
- R2: A read accepted while `rd_valid` is high gives `out_valid` high on the next cycle. When the codeword is error-free, `out_data` equals the encoded data and both flags are low.
- R3: A codeword with exactly one flipped bit, at any of its 72 positions, returns the original data with `out_corr` high and `out_uncorr` low. This includes flips of check bits and of the overall parity bit.
- R4: A codeword with exactly two flipped bits returns `out_uncorr` high and `out_corr` low.
- R5: `corr_count` resets to 0. It increases by one for each read flagged as corrected, and it holds at 2^CNT_W-1 rather than wrapping.
- R6: `last_corr_addr` takes the `rd_addr` of each corrected read. Clean reads and uncorrectable reads leave it unchanged.
- R7: `irq` rises in the same cycle as an `out_uncorr` result and stays high until a cycle with `irq_clear` high. If a clear and a new uncorrectable read arrive in the same cycle, `irq` stays high.
- R8: An uncorrectable read records its page, `rd_addr >> PAGE_SHIFT`, into the lowest free slot of the bad-page table. Slot s occupies `bad_page[s*PAGE_W +: PAGE_W]` and sets `bad_valid[s]`. A page already in the table is not entered again. Once every slot is used, new pages are dropped.
- R9: While `rd_valid` is low, `rd_code` and `rd_addr` are ignored: `out_valid` is low on the next cycle and the counter, last address, interrupt and table do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | DATA_W | Data word to encode |
| wr_code | output | CODE_W | Encoded codeword |
| rd_valid | input | 1 | Read codeword present this cycle |
| rd_code | input | CODE_W | Codeword read from storage |
| rd_addr | input | ADDR_W | Address of the read |
| irq_clear | input | 1 | Write-one pulse that clears the interrupt |
| out_valid | output | 1 | Decoded result valid |
| out_data | output | DATA_W | Decoded, repaired data |
| out_corr | output | 1 | A single-bit error was repaired |
| out_uncorr | output | 1 | Uncorrectable error detected |
| corr_count | output | CNT_W | Saturating count of repaired reads |
| last_corr_addr | output | ADDR_W | Address of the most recent repaired read |
| irq | output | 1 | Sticky uncorrectable-error interrupt |
| bad_page | output | BAD_N*PAGE_W | Bad-page table, slot s at bits s*PAGE_W upward |
| bad_valid | output | BAD_N | Occupied flag per table slot |

## Verification
The bench flips every one of the 72 codeword bits in turn, then every pair of bits. A decoder that mislocates check-bit or parity-bit flips would corrupt data or report them as double errors, and one that confuses the parity cases would repair double errors into wrong data. It drives the counter past its ceiling, where a wrapping counter would return to zero. It repeats a page, where a table without a duplicate match would fill up. It overflows the table, where a design that replaced old entries would lose the first bad pages. Finally, it makes a clear and a new failure coincide, where clear-wins priority would silently drop an interrupt.

// File: rtl/secded_pkg.sv
package secded_pkg;

    // Smallest p with 2^p >= dw + p + 1.
    function automatic int check_bits(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    function automatic logic is_pow2(input int v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    typedef enum logic [1:0] {
        EK_CLEAN     = 2'd0,
        EK_FIX_DATA  = 2'd1,
        EK_FIX_CHECK = 2'd2,
        EK_DOUBLE    = 2'd3
    } err_kind_e;

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
    parameter int DATA_W = 64,
    localparam int P_W    = secded_pkg::check_bits(DATA_W),
    localparam int CODE_W = DATA_W + P_W + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    import secded_pkg::*;

    always_comb begin
        logic [CODE_W-1:0] cw;
        logic              par;
        int                j;
        cw = '0;
        j  = 0;
        // Scatter data into non-power-of-two positions.
        for (int pos = 1; pos < CODE_W; pos++) begin
            if (!is_pow2(pos)) begin
                cw[pos] = data_i[j];
                j++;
            end
        end
        // Each check bit covers positions with its index bit set.
        for (int k = 0; k < P_W; k++) begin
            par = 1'b0;
            for (int pos = 1; pos < CODE_W; pos++) begin
                if (((pos >> k) & 1) == 1) par = par ^ cw[pos];
            end
            cw[1 << k] = par;
        end
        cw[0]  = ^cw[CODE_W-1:1];
        code_o = cw;
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
    parameter int DATA_W = 64,
    localparam int P_W    = secded_pkg::check_bits(DATA_W),
    localparam int CODE_W = DATA_W + P_W + 1
) (
    input  logic [CODE_W-1:0]      code_i,
    output logic [DATA_W-1:0]      data_o,
    output secded_pkg::err_kind_e  kind_o
);
    import secded_pkg::*;

    logic [P_W-1:0]    syn;
    logic              ovr;
    logic [CODE_W-1:0] fixed;

    // Syndrome: recomputed parity groups, including stored check bits.
    always_comb begin
        syn = '0;
        for (int k = 0; k < P_W; k++) begin
            for (int pos = 1; pos < CODE_W; pos++) begin
                if (((pos >> k) & 1) == 1) syn[k] = syn[k] ^ code_i[pos];
            end
        end
        ovr = ^code_i;
    end

    // Classify and repair.
    always_comb begin
        fixed  = code_i;
        kind_o = EK_CLEAN;
        if (syn == '0) begin
            kind_o = ovr ? EK_FIX_CHECK : EK_CLEAN;
        end else if (ovr && (int'(syn) < CODE_W)) begin
            fixed[syn] = ~code_i[syn];
            kind_o     = is_pow2(int'(syn)) ? EK_FIX_CHECK : EK_FIX_DATA;
        end else begin
            kind_o = EK_DOUBLE;
        end
    end

    // Gather data back from non-power-of-two positions.
    always_comb begin
        int j;
        j      = 0;
        data_o = '0;
        for (int pos = 1; pos < CODE_W; pos++) begin
            if (!is_pow2(pos)) begin
                data_o[j] = fixed[pos];
                j++;
            end
        end
    end

endmodule

// File: rtl/secded_log.sv
module secded_log #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int CNT_W      = 16,
    parameter int BAD_N      = 4,
    localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ev_valid,
    input  logic                    ev_corr,
    input  logic                    ev_uncorr,
    input  logic [ADDR_W-1:0]       ev_addr,
    input  logic                    irq_clear,
    output logic [CNT_W-1:0]        cnt_o,
    output logic [ADDR_W-1:0]       last_o,
    output logic                    irq_o,
    output logic [BAD_N*PAGE_W-1:0] pages_o,
    output logic [BAD_N-1:0]        vld_o
);

    typedef struct packed {
        logic [CNT_W-1:0]             cnt;
        logic [ADDR_W-1:0]            last;
        logic                         irq;
        logic [BAD_N-1:0][PAGE_W-1:0] pages;
        logic [BAD_N-1:0]             vld;
    } log_t;

    log_t log_d, log_q;

    logic [PAGE_W-1:0] ev_page;
    assign ev_page = ev_addr[ADDR_W-1:PAGE_SHIFT];

    always_comb begin
        logic hit;
        logic placed;
        log_d = log_q;

        if (ev_valid && ev_corr) begin
            if (log_q.cnt != {CNT_W{1'b1}}) log_d.cnt = log_q.cnt + 1'b1;
            log_d.last = ev_addr;
        end

        // Set has priority over the clear pulse.
        log_d.irq = (log_q.irq && !irq_clear) || (ev_valid && ev_uncorr);

        hit    = 1'b0;
        placed = 1'b0;
        for (int s = 0; s < BAD_N; s++) begin
            if (log_q.vld[s] && (log_q.pages[s] == ev_page)) hit = 1'b1;
        end
        if (ev_valid && ev_uncorr && !hit) begin
            for (int s = 0; s < BAD_N; s++) begin
                if (!placed && !log_q.vld[s]) begin
                    log_d.vld[s]   = 1'b1;
                    log_d.pages[s] = ev_page;
                    placed         = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign cnt_o   = log_q.cnt;
    assign last_o  = log_q.last;
    assign irq_o   = log_q.irq;
    assign pages_o = log_q.pages;
    assign vld_o   = log_q.vld;

endmodule

// File: rtl/secded_guard.sv
module secded_guard #(
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int CNT_W      = 16,
    parameter int BAD_N      = 4,
    localparam int CODE_W    = DATA_W + secded_pkg::check_bits(DATA_W) + 1,
    localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [CODE_W-1:0]       wr_code,
    input  logic                    rd_valid,
    input  logic [CODE_W-1:0]       rd_code,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    irq_clear,
    output logic                    out_valid,
    output logic [DATA_W-1:0]       out_data,
    output logic                    out_corr,
    output logic                    out_uncorr,
    output logic [CNT_W-1:0]        corr_count,
    output logic [ADDR_W-1:0]       last_corr_addr,
    output logic                    irq,
    output logic [BAD_N*PAGE_W-1:0] bad_page,
    output logic [BAD_N-1:0]        bad_valid
);
    import secded_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              corr;
        logic              uncorr;
    } pipe_t;

    pipe_t             pipe_d, pipe_q;
    logic [DATA_W-1:0] dec_data;
    err_kind_e         dec_kind;
    logic              ev_corr, ev_uncorr;

    secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data_i (wr_data),
        .code_o (wr_code)
    );

    secded_dec #(.DATA_W(DATA_W)) u_dec (
        .code_i (rd_code),
        .data_o (dec_data),
        .kind_o (dec_kind)
    );

    assign ev_corr   = (dec_kind == EK_FIX_DATA) || (dec_kind == EK_FIX_CHECK);
    assign ev_uncorr = (dec_kind == EK_DOUBLE);

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.valid  = rd_valid;
        pipe_d.corr   = rd_valid && ev_corr;
        pipe_d.uncorr = rd_valid && ev_uncorr;
        if (rd_valid) pipe_d.data = dec_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid  = pipe_q.valid;
    assign out_data   = pipe_q.data;
    assign out_corr   = pipe_q.corr;
    assign out_uncorr = pipe_q.uncorr;

    secded_log #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .CNT_W      (CNT_W),
        .BAD_N      (BAD_N)
    ) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (rd_valid),
        .ev_corr   (ev_corr),
        .ev_uncorr (ev_uncorr),
        .ev_addr   (rd_addr),
        .irq_clear (irq_clear),
        .cnt_o     (corr_count),
        .last_o    (last_corr_addr),
        .irq_o     (irq),
        .pages_o   (bad_page),
        .vld_o     (bad_valid)
    );

endmodule

// File: rtl/secded_guard_chk.sv
module secded_guard_chk #(
    parameter int CNT_W = 16,
    parameter int BAD_N = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_valid,
    input logic             irq_clear,
    input logic             out_valid,
    input logic             out_corr,
    input logic             out_uncorr,
    input logic [CNT_W-1:0] corr_count,
    input logic             irq,
    input logic [BAD_N-1:0] bad_valid
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> out_valid); // R2
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_corr && out_uncorr)); // R4
    AST_CORR_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_corr |-> out_valid); // R3
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_count == CMAX) |=> (corr_count == CMAX)); // R5
    AST_IRQ_ON_UNCORR: assert property (@(posedge clk) disable iff (!rst_n)
        out_uncorr |-> irq); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq); // R7
    AST_BAD_SLOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bad_valid & $past(bad_valid)) == $past(bad_valid))); // R8
    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !out_valid); // R9
    AST_IDLE_CNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> $stable(corr_count)); // R9

endmodule

bind secded_guard secded_guard_chk #(.CNT_W(CNT_W), .BAD_N(BAD_N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid   (rd_valid),
    .irq_clear  (irq_clear),
    .out_valid  (out_valid),
    .out_corr   (out_corr),
    .out_uncorr (out_uncorr),
    .corr_count (corr_count),
    .irq        (irq),
    .bad_valid  (bad_valid)
);

// File: tb/secded_guard_test.sv
`timescale 1ns/1ps
module secded_guard_test;
    localparam int DW = 64;
    localparam int CW = 72;
    localparam int AW = 16;
    localparam int PS = 8;
    localparam int PW = AW - PS;
    localparam int NW = 3;
    localparam int BN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] wr_code;
    logic          rd_valid = 1'b0;
    logic [CW-1:0] rd_code = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          irq_clear = 1'b0;
    logic          out_valid, out_corr, out_uncorr, irq;
    logic [DW-1:0] out_data;
    logic [NW-1:0] corr_count;
    logic [AW-1:0] last_corr_addr;
    logic [BN*PW-1:0] bad_page;
    logic [BN-1:0] bad_valid;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    secded_guard #(.DATA_W(DW), .ADDR_W(AW), .PAGE_SHIFT(PS), .CNT_W(NW), .BAD_N(BN)) uut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_code(wr_code),
        .rd_valid(rd_valid), .rd_code(rd_code), .rd_addr(rd_addr), .irq_clear(irq_clear),
        .out_valid(out_valid), .out_data(out_data), .out_corr(out_corr),
        .out_uncorr(out_uncorr), .corr_count(corr_count), .last_corr_addr(last_corr_addr),
        .irq(irq), .bad_page(bad_page), .bad_valid(bad_valid)
    );

    function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        int j;
        c = '0;
        j = 0;
        for (int i = 1; i < CW; i++)
            if ((i & (i - 1)) != 0) begin c[i] = d[j]; j++; end
        for (int k = 0; k < 7; k++) begin
            logic p;
            p = 1'b0;
            for (int i = 1; i < CW; i++) if (i[k]) p ^= c[i];
            c[1 << k] = p;
        end
        c[0] = ^c;
        return c;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic rd(input logic v, input logic [CW-1:0] c, input logic [AW-1:0] a,
                      input logic clr);
        rd_valid = v; rd_code = c; rd_addr = a; irq_clear = clr;
        @(negedge clk);
        rd_valid = 1'b0; irq_clear = 1'b0;
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return {32'(i) * 32'h9E3779B1, 32'(i) ^ 32'hC3A5_5A3C};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ncorr;
        logic [DW-1:0] d;
        logic [CW-1:0] c;
        int pidx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset out_valid", out_valid, 0);
        chk("R5 reset count", corr_count, 0);
        chk("R7 reset irq", irq, 0);
        chk("R8 reset bad_valid", bad_valid, 0);

        // R1: walking ones and assorted patterns
        for (int i = 0; i < DW; i++) begin
            wr_data = 64'd1 << i; #1;
            chk("R1 encode walking", wr_code, ref_enc(wr_data));
        end
        for (int i = 0; i < 16; i++) begin
            wr_data = pat(i); #1;
            chk("R1 encode pattern", wr_code, ref_enc(wr_data));
        end
        wr_data = '1; #1;
        chk("R1 encode ones", wr_code, ref_enc(wr_data));
        @(negedge clk);

        // R9: corrupted word with rd_valid low is ignored
        rd(1'b0, ref_enc(64'h1234) ^ 72'h3, 16'h0500, 1'b0);
        chk("R9 idle out_valid", out_valid, 0);
        chk("R9 idle count", corr_count, 0);
        chk("R9 idle irq", irq, 0);
        chk("R9 idle bad_valid", bad_valid, 0);

        // R2: clean reads
        for (int i = 0; i < 8; i++) begin
            rd(1'b1, ref_enc(pat(i + 40)), 16'h0100, 1'b0);
            chk("R2 clean valid", out_valid, 1);
            chk("R2 clean data", out_data, pat(i + 40));
            chk("R2 clean flags", {out_corr, out_uncorr}, 0);
        end
        chk("R6 clean keeps last", last_corr_addr, 0);

        // R8 duplicate page, R7 interrupt set/clear
        rd(1'b1, ref_enc(64'h55) ^ 72'h6, 16'h0305, 1'b0);
        chk("R4 double flag", {out_corr, out_uncorr}, 2'b01);
        chk("R7 irq set", irq, 1);
        rd(1'b1, ref_enc(64'h66) ^ 72'h30, 16'h0377, 1'b0);
        chk("R8 dup valid", bad_valid, 4'b0001);
        chk("R8 dup page", bad_page[PW-1:0], 8'h03);
        rd(1'b0, '0, '0, 1'b1);
        chk("R7 irq cleared", irq, 0);
        rd(1'b1, ref_enc(64'h77) ^ 72'h81, 16'h0300, 1'b1);
        chk("R7 set beats clear", irq, 1);
        rd(1'b0, '0, '0, 1'b0);
        chk("R7 irq held", irq, 1);

        // R3/R5/R6: every single-bit position
        ncorr = 0;
        for (int b = 0; b < CW; b++) begin
            d = pat(b + 100);
            c = ref_enc(d);
            c[b] = ~c[b];
            rd(1'b1, c, AW'(16'h0A00 + b), 1'b0);
            ncorr++;
            chk("R3 single data", out_data, d);
            chk("R3 single flags", {out_corr, out_uncorr}, 2'b10);
            chk("R5 count", corr_count, (ncorr > 7) ? 7 : ncorr);
            chk("R6 last addr", last_corr_addr, 16'h0A00 + b);
        end
        rd(1'b1, ref_enc(64'hABCD), 16'h0F00, 1'b0);
        chk("R6 clean after single", last_corr_addr, 16'h0A00 + CW - 1);
        chk("R5 saturated", corr_count, 7);

        // R4/R8: every pair of bits
        pidx = 0;
        for (int a = 0; a < CW; a++) begin
            for (int b = a + 1; b < CW; b++) begin
                c = ref_enc(pat(pidx));
                c[a] = ~c[a];
                c[b] = ~c[b];
                rd(1'b1, c, AW'(((pidx & 255) << PS) | 5), 1'b0);
                chk("R4 double flags", {out_corr, out_uncorr}, 2'b01);
                pidx++;
            end
        end
        chk("R6 double keeps last", last_corr_addr, 16'h0A00 + CW - 1);
        chk("R8 table full", bad_valid, 4'b1111);
        chk("R8 table order", bad_page, {8'h02, 8'h01, 8'h00, 8'h03});
        chk("R7 irq after sweep", irq, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule